// File: doc/BRIEF.md
# Serial adapter bus register interface

This block is the bus-facing half of a serial adapter. A Wishbone slave decodes an eight-word window of 16-bit registers, keeps the line configuration, the interrupt mask and a 20-bit bit-rate divisor, and holds two small queues. One queue takes characters that the receive shifter delivers. The other holds characters that software hands over for transmission.

Software polls a status word that is built live from the queue flags, or it waits on a single interrupt line gated by the mask. A single data offset serves both directions. Reading it drains the receive queue, and writing it feeds the transmit queue. The shifters, the bit-rate counter and the pins sit outside this block. They connect through the queue ports and through the configuration and divisor outputs.

Top module: `serlink_regfile`

## Requirements
- R1: After reset the configuration, mask and divisor are zero, both queues are empty, irq_o is low and the status word reads 16'h800C.
- R2: ack_o is high in exactly those cycles where cyc_i and stb_i are both high, so every access completes in one cycle.
- R3: Word index 0 (byte offset 0) is the configuration register. Bits 4:0 and 13:8 are stored. Bits 7:5 and 15:14 read as zero. cfg_o carries the stored value.
- R4: Word index 1 (byte offset 2) reads the status word. Bit 0 is high when the receive queue holds data. Bit 1 is high when it is full. Bit 2 is high when the transmit queue is empty. Bit 3 is high when it has room. Bits 14:4 are zero, and bit 15 is high when any of bits 3:0 is high.
- R5: Word index 2 (byte offset 4) is the interrupt mask. Bits 3:0 are stored and match status bits 3:0. Bits 15:4 read as zero.
- R6: irq_o is high exactly when some status bit among 3:0 is high and its mask bit is also set. It is combinational in the default build.
- R7: A read of word index 3 (byte offset 6) returns the oldest received character zero-extended and removes it. If the receive queue is empty, the read returns zero and removes nothing.
- R8: A write of word index 3 appends dat_i[DATA_W-1:0] to the transmit queue. The write is dropped if the queue is full. tx_valid_o and tx_data_o show the queue head, and tx_pop_i removes it.
- R9: Word indices 4 and 5 read as zero. Writes to indices 1, 4 and 5 change no state.
- R10: Word index 6 holds divisor bits 15:0. Bits 3:0 of word index 7 hold divisor bits 19:16, and its upper bits read as zero. divisor_o carries the 20-bit value.
- R11: rx_push_i stores rx_data_i unless the receive queue is full, in which case the character is lost. rx_full_o reports the full state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 4 | Byte address, bit 0 ignored |
| dat_i | input | 16 | Write data |
| dat_o | output | 16 | Read data |
| ack_o | output | 1 | Acknowledge |
| irq_o | output | 1 | Interrupt request |
| rx_push_i | input | 1 | Receive shifter delivers a character |
| rx_data_i | input | DATA_W | Received character |
| rx_full_o | output | 1 | Receive queue full |
| tx_pop_i | input | 1 | Transmit shifter takes the head |
| tx_data_o | output | DATA_W | Transmit queue head |
| tx_valid_o | output | 1 | Transmit queue not empty |
| cfg_o | output | 16 | Stored configuration |
| divisor_o | output | 20 | Bit-rate divisor |

## Verification
The bench builds the block with an 8-bit character, queues four entries deep and the combinational interrupt. With these values a few accesses are enough to fill both queues, so the full flags, the dropped push on each side and the simultaneous push-and-drain case are all reached. A behavioural model keeps the queues and registers, and it is compared on every clock with the interrupt, the queue outputs and every read.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

   typedef enum logic [2:0] {
      IDX_CFG   = 3'd0,
      IDX_STAT  = 3'd1,
      IDX_MASK  = 3'd2,
      IDX_DATA  = 3'd3,
      IDX_NIL0  = 3'd4,
      IDX_NIL1  = 3'd5,
      IDX_DIVLO = 3'd6,
      IDX_DIVHI = 3'd7
   } reg_idx_e;

   localparam int          WORD_W   = 16;
   localparam int          DIV_W    = 20;
   localparam int          DIV_HI_W = DIV_W - WORD_W;
   localparam int          FLAG_W   = 4;
   localparam logic [15:0] CFG_KEEP = 16'h3F1F;

endpackage

// File: rtl/serlink_fifo.sv
module serlink_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          push_i,
   input  logic [W-1:0]  data_i,
   input  logic          pop_i,
   output logic [W-1:0]  head_o,
   output logic          empty_o,
   output logic          full_o,
   output logic [CW-1:0] count_o
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("serlink_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == FULL_CNT);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign head_o  = mem[rd_ptr];
   assign count_o = cnt;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (do_push) mem[wr_ptr] <= data_i;
   end

endmodule

// File: rtl/serlink_status.sv
module serlink_status
   import serlink_pkg::*;
#(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              rx_empty_i,
   input  logic              rx_full_i,
   input  logic              tx_empty_i,
   input  logic              tx_full_i,
   input  logic [FLAG_W-1:0] mask_i,
   output logic [WORD_W-1:0] status_o,
   output logic              irq_o
);

   logic [FLAG_W-1:0] flags;
   logic              hit;

   assign flags    = {~tx_full_i, tx_empty_i, rx_full_i, ~rx_empty_i};
   assign status_o = {(|flags), {(WORD_W - FLAG_W - 1){1'b0}}, flags};
   assign hit      = |(flags & mask_i);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) irq_q <= 1'b0;
            else       irq_q <= hit;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = hit;
      end
   endgenerate

endmodule

// File: rtl/serlink_regfile.sv
module serlink_regfile
   import serlink_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int RX_DEPTH       = 4,
   parameter int TX_DEPTH       = 4,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [3:0]        adr_i,
   input  logic [15:0]       dat_i,
   output logic [15:0]       dat_o,
   output logic              ack_o,
   output logic              irq_o,
   input  logic              rx_push_i,
   input  logic [DATA_W-1:0] rx_data_i,
   output logic              rx_full_o,
   input  logic              tx_pop_i,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_valid_o,
   output logic [15:0]       cfg_o,
   output logic [19:0]       divisor_o
);

   generate
      if (DATA_W < 1 || DATA_W > WORD_W) begin : g_bad_width
         $error("serlink_regfile: DATA_W must lie between 1 and 16");
      end
   endgenerate

   localparam int RX_CW = $clog2(RX_DEPTH) + 1;
   localparam int TX_CW = $clog2(TX_DEPTH) + 1;

   logic              acc, wr, rd;
   reg_idx_e          idx;
   logic [WORD_W-1:0] cfg_q;
   logic [FLAG_W-1:0] mask_q;
   logic [DIV_W-1:0]  div_q;
   logic [WORD_W-1:0] status;
   logic              rx_empty, rx_full, tx_empty, tx_full;
   logic [DATA_W-1:0] rx_head;
   logic [RX_CW-1:0]  rx_cnt;
   logic [TX_CW-1:0]  tx_cnt;
   logic              rx_pop, tx_push;

   assign acc     = cyc_i && stb_i;
   assign wr      = acc && we_i;
   assign rd      = acc && !we_i;
   assign idx     = reg_idx_e'(adr_i[3:1]);
   assign ack_o   = acc;
   assign rx_pop  = rd && (idx == IDX_DATA);
   assign tx_push = wr && (idx == IDX_DATA);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cfg_q  <= '0;
         mask_q <= '0;
         div_q  <= '0;
      end else if (wr) begin
         case (idx)
            IDX_CFG:   cfg_q  <= dat_i & CFG_KEEP;
            IDX_MASK:  mask_q <= dat_i[FLAG_W-1:0];
            IDX_DIVLO: div_q[WORD_W-1:0] <= dat_i;
            IDX_DIVHI: div_q[DIV_W-1:WORD_W] <= dat_i[DIV_HI_W-1:0];
            default:   ;
         endcase
      end
   end

   serlink_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .push_i  (rx_push_i),
      .data_i  (rx_data_i),
      .pop_i   (rx_pop),
      .head_o  (rx_head),
      .empty_o (rx_empty),
      .full_o  (rx_full),
      .count_o (rx_cnt)
   );

   serlink_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .push_i  (tx_push),
      .data_i  (dat_i[DATA_W-1:0]),
      .pop_i   (tx_pop_i),
      .head_o  (tx_data_o),
      .empty_o (tx_empty),
      .full_o  (tx_full),
      .count_o (tx_cnt)
   );

   serlink_status #(.REG_IRQ(IRQ_REGISTERED)) u_stat (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rx_empty_i (rx_empty),
      .rx_full_i  (rx_full),
      .tx_empty_i (tx_empty),
      .tx_full_i  (tx_full),
      .mask_i     (mask_q),
      .status_o   (status),
      .irq_o      (irq_o)
   );

   always_comb begin
      dat_o = '0;
      case (idx)
         IDX_CFG:   dat_o = cfg_q;
         IDX_STAT:  dat_o = status;
         IDX_MASK:  dat_o[FLAG_W-1:0] = mask_q;
         IDX_DATA:  if (!rx_empty) dat_o[DATA_W-1:0] = rx_head;
         IDX_DIVLO: dat_o = div_q[WORD_W-1:0];
         IDX_DIVHI: dat_o[DIV_HI_W-1:0] = div_q[DIV_W-1:WORD_W];
         default:   dat_o = '0;
      endcase
   end

   assign rx_full_o  = rx_full;
   assign tx_valid_o = !tx_empty;
   assign cfg_o      = cfg_q;
   assign divisor_o  = div_q;

endmodule

module serlink_regfile_chk #(
   parameter int RX_DEPTH = 4,
   parameter int TX_DEPTH = 4,
   localparam int RX_CW   = $clog2(RX_DEPTH) + 1,
   localparam int TX_CW   = $clog2(TX_DEPTH) + 1
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             cyc_i,
   input logic             stb_i,
   input logic             we_i,
   input logic [3:0]       adr_i,
   input logic [15:0]      dat_o,
   input logic             irq_o,
   input logic [3:0]       mask_q,
   input logic [RX_CW-1:0] rx_cnt,
   input logic [TX_CW-1:0] tx_cnt,
   input logic             rx_push_i,
   input logic             tx_pop_i
);

   localparam logic [RX_CW-1:0] RX_TOP = RX_CW'(RX_DEPTH);
   localparam logic [TX_CW-1:0] TX_TOP = TX_CW'(TX_DEPTH);

   logic       rd_c, wr_c;
   logic [2:0] w;
   assign rd_c = cyc_i && stb_i && !we_i;
   assign wr_c = cyc_i && stb_i && we_i;
   assign w    = adr_i[3:1];

   assert_stat_sum_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_c && w == 3'd1) |-> (dat_o[15] == (dat_o[3:0] != 4'd0)) && (dat_o[14:4] == 11'd0));

   assert_rx_empty_read_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_c && w == 3'd3 && rx_cnt == '0) |-> dat_o == 16'd0);

   assert_rx_pop_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_c && w == 3'd3 && rx_cnt != '0 && !rx_push_i) |=> rx_cnt == $past(rx_cnt) - 1'b1);

   assert_tx_drop_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_c && w == 3'd3 && tx_cnt == TX_TOP && !tx_pop_i) |=> tx_cnt == TX_TOP);

   assert_unused_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_c && (w == 3'd4 || w == 3'd5)) |-> dat_o == 16'd0);

   assert_div_hi_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_c && w == 3'd7) |-> dat_o[15:4] == 12'd0);

   assert_irq_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (mask_q == 4'd0 && $past(mask_q) == 4'd0) |-> !irq_o);

   assert_rx_drop_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (rx_push_i && rx_cnt == RX_TOP && !(rd_c && w == 3'd3)) |=> rx_cnt == RX_TOP);

endmodule

bind serlink_regfile serlink_regfile_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .cyc_i     (cyc_i),
   .stb_i     (stb_i),
   .we_i      (we_i),
   .adr_i     (adr_i),
   .dat_o     (dat_o),
   .irq_o     (irq_o),
   .mask_q    (mask_q),
   .rx_cnt    (rx_cnt),
   .tx_cnt    (tx_cnt),
   .rx_push_i (rx_push_i),
   .tx_pop_i  (tx_pop_i)
);

// File: tb/serlink_regfile_test.sv
module serlink_regfile_test;

   localparam int DW = 8;
   localparam int RXD = 4;
   localparam int TXD = 4;

   logic        clk = 1'b0;
   logic        rst_i;
   logic        cyc_i, stb_i, we_i;
   logic [3:0]  adr_i;
   logic [15:0] dat_i;
   logic [15:0] dat_o;
   logic        ack_o, irq_o;
   logic        rx_push_i;
   logic [7:0]  rx_data_i;
   logic        rx_full_o;
   logic        tx_pop_i;
   logic [7:0]  tx_data_o;
   logic        tx_valid_o;
   logic [15:0] cfg_o;
   logic [19:0] divisor_o;

   always #10 clk = ~clk;

   serlink_regfile #(.DATA_W(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) uut (
      .clk_i(clk), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
      .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o), .irq_o(irq_o),
      .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .rx_full_o(rx_full_o),
      .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
      .cfg_o(cfg_o), .divisor_o(divisor_o)
   );

   int vectors = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0]  rxq[$];
   logic [7:0]  txq[$];
   logic [15:0] m_cfg;
   logic [3:0]  m_mask;
   logic [19:0] m_div;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] m_status();
      logic [3:0] f;
      f = {rxq.size() < RXD ? 1'b1 : 1'b0, 1'b0, 1'b0, 1'b0};
      f[3] = (txq.size() < TXD);
      f[2] = (txq.size() == 0);
      f[1] = (rxq.size() == RXD);
      f[0] = (rxq.size() != 0);
      return {(f != 4'd0), 11'd0, f};
   endfunction

   function automatic logic [15:0] m_read(input logic [2:0] w);
      case (w)
         3'd0: return m_cfg;
         3'd1: return m_status();
         3'd2: return {12'd0, m_mask};
         3'd3: return (rxq.size() != 0) ? {8'd0, rxq[0]} : 16'd0;
         3'd6: return m_div[15:0];
         3'd7: return {12'd0, m_div[19:16]};
         default: return 16'd0;
      endcase
   endfunction

   function automatic string rtag(input logic [2:0] w);
      case (w)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R7";
         3'd4, 3'd5: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic compare_all();
      logic [15:0] s;
      s = m_status();
      chk("R3", {16'd0, cfg_o}, {16'd0, m_cfg});
      chk("R10", {12'd0, divisor_o}, {12'd0, m_div});
      chk("R6", {31'd0, irq_o}, {31'd0, |(s[3:0] & m_mask)});
      chk("R8", {31'd0, tx_valid_o}, {31'd0, txq.size() != 0});
      if (txq.size() != 0) chk("R8", {24'd0, tx_data_o}, {24'd0, txq[0]});
      chk("R11", {31'd0, rx_full_o}, {31'd0, rxq.size() == RXD});
   endtask

   // One clock: drive at negedge, check reads before the edge, update model at the edge.
   task automatic step(input logic c, input logic s, input logic we, input logic [3:0] a,
                       input logic [15:0] d, input logic rp, input logic [7:0] rd,
                       input logic tp);
      logic [2:0] w;
      bit rx_pop_ok, rx_push_ok, tx_push_ok, tx_pop_ok;
      cyc_i = c; stb_i = s; we_i = we; adr_i = a; dat_i = d;
      rx_push_i = rp; rx_data_i = rd; tx_pop_i = tp;
      w = a[3:1];
      #2;
      chk("R2", {31'd0, ack_o}, {31'd0, c && s});
      if (c && s && !we) chk(rtag(w), {16'd0, dat_o}, {16'd0, m_read(w)});
      @(posedge clk);
      rx_pop_ok  = c && s && !we && w == 3'd3 && rxq.size() != 0;
      rx_push_ok = rp && rxq.size() < RXD;
      tx_push_ok = c && s && we && w == 3'd3 && txq.size() < TXD;
      tx_pop_ok  = tp && txq.size() != 0;
      if (c && s && we) begin
         case (w)
            3'd0: m_cfg = d & 16'h3F1F;
            3'd2: m_mask = d[3:0];
            3'd6: m_div[15:0] = d;
            3'd7: m_div[19:16] = d[3:0];
            default: ;
         endcase
      end
      if (rx_pop_ok)  void'(rxq.pop_front());
      if (rx_push_ok) rxq.push_back(rd);
      if (tx_pop_ok)  void'(txq.pop_front());
      if (tx_push_ok) txq.push_back(d[7:0]);
      @(negedge clk);
      compare_all();
   endtask

   task automatic bwr(input logic [3:0] a, input logic [15:0] d);
      step(1, 1, 1, a, d, 0, 8'h00, 0);
   endtask

   task automatic brd(input logic [3:0] a);
      step(1, 1, 0, a, 16'h0, 0, 8'h00, 0);
   endtask

   task automatic rxin(input logic [7:0] b);
      step(0, 0, 0, 4'h0, 16'h0, 1, b, 0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   end

   initial begin
      rst_i = 1; cyc_i = 0; stb_i = 0; we_i = 0; adr_i = 0; dat_i = 0;
      rx_push_i = 0; rx_data_i = 0; tx_pop_i = 0;
      m_cfg = 0; m_mask = 0; m_div = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_i = 0;
      // R1: reset state
      #2;
      chk("R1", {16'd0, cfg_o}, 32'd0);
      chk("R1", {31'd0, irq_o}, 32'd0);
      chk("R1", {12'd0, divisor_o}, 32'd0);
      brd(4'h2);
      chk("R1", {16'd0, m_status()}, 32'h800C);
      for (int i = 0; i < 16; i += 2) brd(i[3:0]);

      // R3: configuration keeps only writable bits
      bwr(4'h0, 16'hFFFF); brd(4'h0);
      bwr(4'h0, 16'h2A15); brd(4'h0);

      // R9: writes to status and unused words do nothing
      bwr(4'h2, 16'hFFFF); bwr(4'h8, 16'hFFFF); bwr(4'hA, 16'hFFFF);
      brd(4'h2); brd(4'h8); brd(4'hA); brd(4'h0);

      // R2: strobe without cycle is not acknowledged
      step(0, 1, 0, 4'h0, 16'h0, 0, 8'h0, 0);
      step(1, 0, 1, 4'h0, 16'h1234, 0, 8'h0, 0);
      brd(4'h0);

      // R5, R6: mask and interrupt
      bwr(4'h4, 16'hFFFF); brd(4'h4);
      bwr(4'h4, 16'h0001);
      rxin(8'h5A);
      bwr(4'h4, 16'h0000);

      // R7: ordered reads, then empty read
      rxin(8'hC3); rxin(8'h11);
      brd(4'h6); brd(4'h6); brd(4'h6); brd(4'h6); brd(4'h2);

      // R11, R4: fill receive queue and overflow
      bwr(4'h4, 16'h0002);
      for (int i = 0; i < RXD + 2; i++) rxin(8'h80 + 8'(i));
      brd(4'h2);
      // R7 with simultaneous push and drain while full
      step(1, 1, 0, 4'h6, 16'h0, 1, 8'hEE, 0);
      for (int i = 0; i < RXD + 1; i++) brd(4'h6);

      // R8: transmit fill, overflow, drain
      bwr(4'h4, 16'h0004);
      for (int i = 0; i < TXD + 1; i++) bwr(4'h6, 16'hAB00 + 16'(i * 7));
      brd(4'h2);
      step(1, 1, 1, 4'h6, 16'h0099, 0, 8'h0, 1);
      for (int i = 0; i < TXD + 1; i++) step(0, 0, 0, 4'h0, 16'h0, 0, 8'h0, 1);
      brd(4'h2);

      // R10: divisor halves
      bwr(4'hC, 16'hABCD); bwr(4'hE, 16'hFFFF);
      brd(4'hC); brd(4'hE);
      bwr(4'hE, 16'h0003); brd(4'hE);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end

endmodule